// File: doc/BRIEF.md
# Two-Access Memory Copy Engine

This block is a single-channel copy engine. It moves a run of data words from one region of the address space to another and keeps the processor out of the data path. Software supplies a source address, a destination address and a word count, then pulses a start input. The engine asks the processor for ownership of the system bus. Once it is granted, it fetches each word from the source into an internal holding register and writes that register out to the destination. Each word therefore costs two separate bus accesses.

Both addresses are given explicitly, and both step forward by one word after every copied element. A bus slave can stretch any access by holding ready low. It can also report a fault along with ready. A fault ends the run at once and releases the bus. The engine raises its interrupt both when a run finishes normally and when a fault ends it. The interrupt stays up until software acknowledges it, and new start pulses are ignored until then. A zero word count finishes immediately and never touches the bus.

Top module: `dma_dual_engine`

## Requirements
- R1: After reset, `bus_req`, `m_rd`, `m_wr`, `irq` and `err_flag` are all low.
- R2: A start with a nonzero count and no pending interrupt raises `bus_req` in the next cycle. `bus_req` stays high until the run ends.
- R3: Element i (from 0) is read at `cfg_src + i*STEP` and then written at `cfg_dst + i*STEP`, where STEP is DATA_W/8 bytes. The written data equals the data returned by that read. Addresses wrap modulo 2^ADDR_W.
- R4: While an access waits (`m_ready` low), `m_addr`, `m_rd`, `m_wr` and `m_wdata` stay unchanged.
- R5: `m_rd` and `m_wr` are never high together. A write of element i happens only after the read of element i has completed.
- R6: `m_err` high together with `m_ready` during an access ends the run. In the next cycle `bus_req` is low and both `irq` and `err_flag` are high. No further accesses follow.
- R7: After the last write completes, `irq` rises with `bus_req` low. `irq` then stays high until `irq_clear` is pulsed, and it is low in the cycle after that pulse. `err_flag` is also cleared by that pulse.
- R8: A start while `irq` is high is ignored. No bus request and no access follow, and `irq` stays high.
- R9: A start with a count of zero sets `irq` in the next cycle. It raises no bus request and makes no access.
- R10: `m_rd` or `m_wr` is high only while `bus_req` is high and `bus_gnt` has been granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src | input | ADDR_W | Byte address of the first source word |
| cfg_dst | input | ADDR_W | Byte address of the first destination word |
| cfg_len | input | LEN_W | Number of words to copy |
| cfg_start | input | 1 | One-cycle pulse that begins a run |
| irq_clear | input | 1 | Acknowledge: drops irq and err_flag |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Bus ownership granted |
| m_addr | output | ADDR_W | Access address |
| m_rd | output | 1 | Read access active |
| m_wr | output | 1 | Write access active |
| m_wdata | output | DATA_W | Write data (holding register) |
| m_rdata | input | DATA_W | Read data, valid with m_ready |
| m_ready | input | 1 | Access completes this cycle |
| m_err | input | 1 | Access fault, valid with m_ready |
| irq | output | 1 | Completion or fault interrupt |
| err_flag | output | 1 | The last run ended on a fault |

## Verification
If the state register goes wrong, the result shows on the bus before the run ends. It may appear as a read and a write active together, an access with no request raised, or a fault followed by more traffic. Each of these is visible in the cycle it happens. A wrong address counter or holding register shows as a mismatched address or data word at the first affected element, and the bus model compares every completed access against values computed from the start configuration. A wrong word counter shows up only at the end of a run, as an early or late interrupt, so the bench also compares the number of accesses seen when the interrupt rises.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_NEXT  = 3'd4,
        ST_DONE  = 3'd5,
        ST_ERR   = 3'd6
    } dma_state_e;
endpackage

// File: rtl/dma_addr_gen.sv
// Source and destination pointers; loaded at start, stepped after each element.
module dma_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            ptr_d.src = src_in;
            ptr_d.dst = dst_in;
        end else if (advance) begin
            ptr_d.src = ptr_q.src + STEP_V;
            ptr_d.dst = ptr_q.dst + STEP_V;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign src_addr = ptr_q.src;
    assign dst_addr = ptr_q.dst;
endmodule

// File: rtl/dma_len_ctr.sv
// Remaining-word counter; flags the final element.
module dma_len_ctr #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [LEN_W-1:0] len_in,
    output logic             cnt_last
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                     cnt_d = len_in;
        else if (dec && cnt_q != '0)  cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_last = (cnt_q == ONE);
endmodule

// File: rtl/dma_ctrl.sv
// Sequencer: bus ownership, read/write alternation, holding register, interrupt.
module dma_ctrl
    import dma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              len_zero,
    input  logic              irq_clear,
    input  logic              bus_gnt,
    input  logic              m_ready,
    input  logic              m_err,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              cnt_last,
    output logic              load,
    output logic              advance,
    output dma_state_e        state,
    output logic [DATA_W-1:0] hold_data,
    output logic              irq,
    output logic              err_flag
);
    typedef struct packed {
        dma_state_e        st;
        logic [DATA_W-1:0] hold;
        logic              irq;
        logic              err;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        load  = 1'b0;
        if (irq_clear) begin
            ctl_d.irq = 1'b0;
            ctl_d.err = 1'b0;
        end
        case (ctl_q.st)
            ST_IDLE: begin
                if (start && !ctl_q.irq) begin
                    if (len_zero) begin
                        ctl_d.st  = ST_DONE;
                        ctl_d.irq = 1'b1;
                    end else begin
                        ctl_d.st = ST_REQ;
                        load     = 1'b1;
                    end
                end
            end
            ST_REQ: begin
                if (bus_gnt) ctl_d.st = ST_READ;
            end
            ST_READ: begin
                if (m_ready) begin
                    if (m_err) begin
                        ctl_d.st  = ST_ERR;
                        ctl_d.irq = 1'b1;
                        ctl_d.err = 1'b1;
                    end else begin
                        ctl_d.hold = m_rdata;
                        ctl_d.st   = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (m_ready) begin
                    if (m_err) begin
                        ctl_d.st  = ST_ERR;
                        ctl_d.irq = 1'b1;
                        ctl_d.err = 1'b1;
                    end else begin
                        ctl_d.st = ST_NEXT;
                    end
                end
            end
            ST_NEXT: begin
                if (cnt_last) begin
                    ctl_d.st  = ST_DONE;
                    ctl_d.irq = 1'b1;
                end else if (bus_gnt) begin
                    ctl_d.st = ST_READ;
                end else begin
                    ctl_d.st = ST_REQ;
                end
            end
            ST_DONE, ST_ERR: ctl_d.st = ST_IDLE;
            default:         ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.hold <= '0;
            ctl_q.irq  <= 1'b0;
            ctl_q.err  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign advance   = (ctl_q.st == ST_NEXT);
    assign state     = ctl_q.st;
    assign hold_data = ctl_q.hold;
    assign irq       = ctl_q.irq;
    assign err_flag  = ctl_q.err;
endmodule

// File: rtl/dma_dual_engine.sv
module dma_dual_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_start,
    input  logic              irq_clear,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] m_addr,
    output logic              m_rd,
    output logic              m_wr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_ready,
    input  logic              m_err,
    output logic              irq,
    output logic              err_flag
);
    localparam int STEP = DATA_W / 8;

    dma_state_e        state;
    logic              load, advance, cnt_last;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [DATA_W-1:0] hold_data;

    dma_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cfg_start),
        .len_zero  (cfg_len == '0),
        .irq_clear (irq_clear),
        .bus_gnt   (bus_gnt),
        .m_ready   (m_ready),
        .m_err     (m_err),
        .m_rdata   (m_rdata),
        .cnt_last  (cnt_last),
        .load      (load),
        .advance   (advance),
        .state     (state),
        .hold_data (hold_data),
        .irq       (irq),
        .err_flag  (err_flag)
    );

    dma_addr_gen #(.ADDR_W(ADDR_W), .STEP(STEP)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (advance),
        .src_in   (cfg_src),
        .dst_in   (cfg_dst),
        .src_addr (src_addr),
        .dst_addr (dst_addr)
    );

    dma_len_ctr #(.LEN_W(LEN_W)) len_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .dec      (advance),
        .len_in   (cfg_len),
        .cnt_last (cnt_last)
    );

    assign bus_req = (state == ST_REQ) || (state == ST_READ) ||
                     (state == ST_WRITE) || (state == ST_NEXT);
    assign m_rd    = (state == ST_READ);
    assign m_wr    = (state == ST_WRITE);
    assign m_addr  = m_wr ? dst_addr : src_addr;
    assign m_wdata = hold_data;
endmodule

// File: rtl/dma_dual_engine_chk.sv
module dma_dual_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [ADDR_W-1:0] m_addr,
    input logic              m_rd,
    input logic              m_wr,
    input logic [DATA_W-1:0] m_wdata,
    input logic              m_ready,
    input logic              m_err,
    input logic              irq,
    input logic              irq_clear,
    input logic              err_flag
);
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_rd && m_wr)); // R5

    AST_ACCESS_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd || m_wr) |-> (bus_req && bus_gnt)); // R10

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_rd || m_wr) && !m_ready) |=>
            ($stable(m_addr) && $stable(m_rd) && $stable(m_wr) && $stable(m_wdata))); // R4

    AST_FAULT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_rd || m_wr) && m_ready && m_err) |=>
            (!bus_req && irq && err_flag && !m_rd && !m_wr)); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq); // R7

    AST_PENDING_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !bus_req); // R8
endmodule

bind dma_dual_engine dma_dual_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .m_addr    (m_addr),
    .m_rd      (m_rd),
    .m_wr      (m_wr),
    .m_wdata   (m_wdata),
    .m_ready   (m_ready),
    .m_err     (m_err),
    .irq       (irq),
    .irq_clear (irq_clear),
    .err_flag  (err_flag)
);

// File: tb/dma_dual_engine_tb_top.sv
`timescale 1ns/1ps
module dma_dual_engine_tb_top;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 16;
    localparam int STEP   = DATA_W / 8;
    localparam int LOGN   = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_src = '0, cfg_dst = '0;
    logic [LEN_W-1:0]  cfg_len = '0;
    logic              cfg_start = 1'b0, irq_clear = 1'b0;
    logic              bus_req, bus_gnt = 1'b0;
    logic [ADDR_W-1:0] m_addr;
    logic              m_rd, m_wr;
    logic [DATA_W-1:0] m_wdata, m_rdata = '0;
    logic              m_ready = 1'b0, m_err = 1'b0;
    logic              irq, err_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bus model state
    int acc_idx = 0;
    int err_at = -1;
    int wait_left = 0;
    int max_wait = 0;
    int n_rd = 0, n_wr = 0;
    int req_cycles = 0;
    int no_gnt_acc = 0;
    logic [ADDR_W-1:0] rd_addr [LOGN];
    logic [ADDR_W-1:0] wr_addr [LOGN];
    logic [DATA_W-1:0] wr_data [LOGN];

    dma_dual_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_len(cfg_len), .cfg_start(cfg_start), .irq_clear(irq_clear),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .m_addr(m_addr), .m_rd(m_rd),
        .m_wr(m_wr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready),
        .m_err(m_err), .irq(irq), .err_flag(err_flag)
    );

    always #2 clk = ~clk;

    function automatic logic [DATA_W-1:0] mem_val(logic [ADDR_W-1:0] a);
        return (a * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // bus slave and grant model, all driven at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req) req_cycles++;
            if (!bus_req)                       bus_gnt <= 1'b0;
            else if (!bus_gnt && $urandom_range(0, 2) == 0) bus_gnt <= 1'b1;
            m_ready <= 1'b0;
            m_err   <= 1'b0;
            if (m_rd || m_wr) begin
                if (!bus_gnt) no_gnt_acc++;
                m_rdata <= mem_val(m_addr);
                if (wait_left > 0) begin
                    wait_left--;
                end else begin
                    m_ready <= 1'b1;
                    if (acc_idx == err_at) begin
                        m_err <= 1'b1;
                    end else if (m_rd) begin
                        if (n_rd < LOGN) rd_addr[n_rd] = m_addr;
                        n_rd++;
                    end else begin
                        if (n_wr < LOGN) begin
                            wr_addr[n_wr] = m_addr;
                            wr_data[n_wr] = m_wdata;
                        end
                        n_wr++;
                    end
                    acc_idx++;
                    wait_left = (max_wait == 0) ? 0 : $urandom_range(0, max_wait);
                end
            end
        end
    end

    task automatic clear_log();
        acc_idx = 0; n_rd = 0; n_wr = 0; req_cycles = 0; no_gnt_acc = 0;
    endtask

    task automatic pulse_start(logic [ADDR_W-1:0] s, logic [ADDR_W-1:0] d, int len);
        cfg_src = s; cfg_dst = d; cfg_len = LEN_W'(len);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    task automatic ack_irq();
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        check(irq == 1'b0, "R7 irq cleared", 64'(irq), 0);
        check(err_flag == 1'b0, "R7 err_flag cleared", 64'(err_flag), 0);
    endtask

    task automatic run_xfer(logic [ADDR_W-1:0] s, logic [ADDR_W-1:0] d, int len, int e_at, int mw);
        int exp_wr;
        int t;
        bit fault;
        clear_log();
        err_at = e_at;
        max_wait = mw;
        wait_left = 0;
        fault = (e_at >= 0) && (e_at < 2 * len);
        exp_wr = fault ? e_at / 2 : len;
        pulse_start(s, d, len);
        check(bus_req == 1'b1, "R2 bus_req after start", 64'(bus_req), 1);
        t = 0;
        while (!irq && t < 4000) begin
            @(negedge clk);
            t++;
        end
        check(irq == 1'b1, "R7 irq raised", 64'(irq), 1);
        check(bus_req == 1'b0, "R7 bus released at irq", 64'(bus_req), 0);
        check(err_flag == fault, "R6 err_flag", 64'(err_flag), 64'(fault));
        check(n_wr == exp_wr, "R3 write count", 64'(n_wr), 64'(exp_wr));
        check(n_rd == (fault ? (e_at + 1) / 2 : len), "R5 read count", 64'(n_rd),
              64'(fault ? (e_at + 1) / 2 : len));
        check(no_gnt_acc == 0, "R10 access without grant", 64'(no_gnt_acc), 0);
        for (int i = 0; i < exp_wr && i < LOGN; i++) begin
            logic [ADDR_W-1:0] sa, da;
            sa = s + ADDR_W'(i * STEP);
            da = d + ADDR_W'(i * STEP);
            check(rd_addr[i] == sa, "R3 read address", 64'(rd_addr[i]), 64'(sa));
            check(wr_addr[i] == da, "R3 write address", 64'(wr_addr[i]), 64'(da));
            check(wr_data[i] == mem_val(sa), "R3 write data", 64'(wr_data[i]), 64'(mem_val(sa)));
        end
        for (int k = 0; k < 3; k++) @(negedge clk);
        check(irq == 1'b1, "R7 irq held", 64'(irq), 1);
        check(n_wr == exp_wr, "R6 no traffic after end", 64'(n_wr), 64'(exp_wr));
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_req == 0, "R1 bus_req reset", 64'(bus_req), 0);
        check(m_rd == 0 && m_wr == 0, "R1 no access reset", 64'({m_rd, m_wr}), 0);
        check(irq == 0, "R1 irq reset", 64'(irq), 0);
        check(err_flag == 0, "R1 err_flag reset", 64'(err_flag), 0);

        // R9 zero-length
        clear_log();
        pulse_start(32'h100, 32'h200, 0);
        check(irq == 1'b1, "R9 zero length irq", 64'(irq), 1);
        check(req_cycles == 0, "R9 no bus request", 64'(req_cycles), 0);
        check(n_rd + n_wr == 0, "R9 no access", 64'(n_rd + n_wr), 0);
        ack_irq();

        // directed
        run_xfer(32'h0000_1000, 32'h0000_8000, 1, -1, 0);
        ack_irq();
        run_xfer(32'h0000_2000, 32'h0000_3000, 5, -1, 3);

        // R8 start ignored while interrupt pending
        clear_log();
        pulse_start(32'h4000, 32'h5000, 4);
        for (int k = 0; k < 10; k++) @(negedge clk);
        check(req_cycles == 0, "R8 start ignored: no request", 64'(req_cycles), 0);
        check(n_rd + n_wr == 0, "R8 start ignored: no access", 64'(n_rd + n_wr), 0);
        check(irq == 1'b1, "R8 irq still pending", 64'(irq), 1);
        ack_irq();

        // address wrap
        run_xfer(32'hFFFF_FFF8, 32'hFFFF_FFF0, 4, -1, 1);
        ack_irq();
        // fault on first read, and on a write
        run_xfer(32'h0000_6000, 32'h0000_7000, 3, 0, 0);
        ack_irq();
        run_xfer(32'h0000_6000, 32'h0000_7000, 4, 3, 2);
        ack_irq();

        // random
        for (int n = 0; n < 12; n++) begin
            int len, ea;
            logic [ADDR_W-1:0] s, d;
            len = $urandom_range(1, 20);
            s = {$urandom_range(0, 32'hFFFF), 16'h0} | ADDR_W'($urandom_range(0, 255) * STEP);
            d = {$urandom_range(0, 32'hFFFF), 16'h0};
            ea = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 2 * len - 1) : -1;
            run_xfer(s, d, len, ea, $urandom_range(0, 3));
            ack_irq();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule